// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two packed single-precision floating-point words, a left operand and a right operand. It returns the outcome as a four-bit condition vector (negative, zero, carry, overflow) and an invalid-operation flag. The logic is purely combinational, so a result is valid in the same cycle that its operands are presented. It is meant to sit between an operand-read stage and a status-update stage, and it loads and stores nothing itself.

Two control inputs choose the compare flavour. The first selects a signalling compare, in which any NaN raises invalid. When it is clear, only signalling NaNs raise invalid. The second makes the right operand an encoded positive zero, so the right-operand input is ignored. Both signed zeros count as equal. All other ordered values are ranked by comparing their raw encodings as sign-magnitude integers.

Top module: `fcmp_flags`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is nonzero is a NaN. If either operand is a NaN, the condition output is unordered, 4'b0011 (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V).
- R2: When the signalling-compare input is low, invalid is set only for a NaN whose fraction bit 22 is clear (a signalling NaN). A NaN with bit 22 set (a quiet NaN) leaves invalid low.
- R3: When the signalling-compare input is high, invalid is set whenever either operand is a NaN of either kind.
- R4: Equal operands give 4'b0110. This includes +0 against -0 in either order.
- R5: When the signs differ and the operands are not both zeros, a negative left operand gives less-than, 4'b1000. A positive left operand gives greater-than, 4'b0010.
- R6: When the signs match, the encodings are compared as unsigned integers. For two positive values, the smaller encoding is less-than (4'b1000). For two negative values, the sense is reversed: the smaller encoding gives greater-than (4'b0010).
- R7: When the compare-with-zero input is high, the right operand is taken to be the encoding 0x00000000. The value on the right-operand input then has no effect on either output.
- R8: The condition output always carries exactly one of 4'b0110, 4'b1000, 4'b0010 or 4'b0011.
- R9: Invalid is never set when neither effective operand is a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Left operand, packed single precision |
| opb_i | input | 32 | Right operand, packed single precision |
| signal_all_i | input | 1 | High selects the signalling compare: any NaN raises invalid |
| vs_zero_i | input | 1 | High replaces the right operand with +0 |
| nzcv_o | output | 4 | Condition vector {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Two functions of the block can act in the same evaluation: zero substitution and NaN screening. With the compare-with-zero input high, a signalling NaN placed on the right-operand input must be ignored. The same stimulus with a NaN on the left operand must still report unordered. The bench sweeps every left-operand class against such a poisoned right operand and judges the outputs against a model that only ever sees +0 on the right. Separately, every pairing of ten operand classes is run in both compare flavours. This checks that the unordered verdict and the invalid verdict each follow their own rule when they occur together.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam logic [3:0] FLAGS_EQ = 4'b0110;
  localparam logic [3:0] FLAGS_LT = 4'b1000;
  localparam logic [3:0] FLAGS_GT = 4'b0010;
  localparam logic [3:0] FLAGS_UN = 4'b0011;

  typedef struct packed {
    logic nan;        // exponent all ones, fraction nonzero
    logic quiet_clr;  // fraction MSB clear
    logic mag_zero;   // all bits below the sign are zero
    logic neg;        // sign bit
  } opnd_cls_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output opnd_cls_t             cls_o
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  assign expo = word_i[W-2 -: EXP_W];
  assign frac = word_i[FRAC_W-1:0];

  always_comb begin
    cls_o.nan       = (&expo) && (|frac);
    cls_o.quiet_clr = ~frac[FRAC_W-1];
    cls_o.mag_zero  = ~|word_i[W-2:0];
    cls_o.neg       = word_i[W-1];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         a_neg_i,
  input  logic         b_neg_i,
  input  logic         a_zero_i,
  input  logic         b_zero_i,
  output logic [3:0]   flags_o
);
  logic raw_lt;

  assign raw_lt = a_i < b_i;

  always_comb begin
    if ((a_i == b_i) || (a_zero_i && b_zero_i)) begin
      flags_o = FLAGS_EQ;
    end else if (a_neg_i != b_neg_i) begin
      flags_o = a_neg_i ? FLAGS_LT : FLAGS_GT;
    end else if (a_neg_i ^ raw_lt) begin
      flags_o = FLAGS_LT;
    end else begin
      flags_o = FLAGS_GT;
    end
  end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opa_i,
  input  logic [EXP_W+FRAC_W:0] opb_i,
  input  logic                  signal_all_i,
  input  logic                  vs_zero_i,
  output logic [3:0]            nzcv_o,
  output logic                  invalid_o
);
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int N_OPS = 2;

  logic [W-1:0] opnd [N_OPS];
  opnd_cls_t    cls  [N_OPS];
  logic [3:0]   ord_flags;
  logic         unord;
  logic [N_OPS-1:0] op_inv;

  assign opnd[0] = opa_i;
  assign opnd[1] = vs_zero_i ? '0 : opb_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word_i (opnd[g]),
      .cls_o  (cls[g])
    );
    assign op_inv[g] = cls[g].nan && (signal_all_i || cls[g].quiet_clr);
  end

  fcmp_order #(.W(W)) u_order (
    .a_i      (opnd[0]),
    .b_i      (opnd[1]),
    .a_neg_i  (cls[0].neg),
    .b_neg_i  (cls[1].neg),
    .a_zero_i (cls[0].mag_zero),
    .b_zero_i (cls[1].mag_zero),
    .flags_o  (ord_flags)
  );

  assign unord     = cls[0].nan || cls[1].nan;
  assign nzcv_o    = unord ? FLAGS_UN : ord_flags;
  assign invalid_o = |op_inv;

  always_comb begin
    // R8
    legal_code_chk: assert (nzcv_o == FLAGS_EQ || nzcv_o == FLAGS_LT ||
                            nzcv_o == FLAGS_GT || nzcv_o == FLAGS_UN)
      else $error("R8 illegal condition code %b", nzcv_o);
    // R9
    inv_needs_nan_chk: assert (!invalid_o || nzcv_o == FLAGS_UN)
      else $error("R9 invalid raised on ordered operands");
    // R4
    zeros_equal_chk: assert (!(opa_i[W-2:0] == '0 && opnd[1][W-2:0] == '0) ||
                             nzcv_o == FLAGS_EQ)
      else $error("R4 signed zeros not equal");
    // R5
    sign_split_chk: assert (!(nzcv_o != FLAGS_UN && opa_i[W-1] != opnd[1][W-1] &&
                              !(cls[0].mag_zero && cls[1].mag_zero)) ||
                            nzcv_o == (opa_i[W-1] ? FLAGS_LT : FLAGS_GT))
      else $error("R5 mixed-sign order wrong");
    // R3
    sig_any_nan_chk: assert (!(signal_all_i && nzcv_o == FLAGS_UN) || invalid_o)
      else $error("R3 signalling compare missed invalid");
  end
endmodule

// File: tb/tb_fcmp_flags.sv
module tb_fcmp_flags;
  logic        clk;
  logic [31:0] opa, opb;
  logic        sig_all, vs_zero;
  logic [3:0]  nzcv;
  logic        inv;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 0;

  initial clk = 0;
  always #5 clk = ~clk;

  fcmp_flags dut (
    .opa_i(opa), .opb_i(opb), .signal_all_i(sig_all), .vs_zero_i(vs_zero),
    .nzcv_o(nzcv), .invalid_o(inv)
  );

  // class encodings: +0,-0,+den,-den,+norm,-norm,+inf,-inf,qnan,snan
  function automatic logic [31:0] enc(int c);
    case (c)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h0000_0001;
      3: return 32'h8000_0001;
      4: return 32'h3f80_0000;
      5: return 32'hbf80_0000;
      6: return 32'h7f80_0000;
      7: return 32'hff80_0000;
      8: return 32'h7fc0_0000;
      default: return 32'h7f80_0001;
    endcase
  endfunction

  function automatic int rank(int c);
    case (c)
      0, 1: return 3;
      2: return 4;
      3: return 2;
      4: return 5;
      5: return 1;
      6: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [4:0] model(int ca, int cb, logic s);
    logic [3:0] f;
    logic       v;
    if (ca >= 8 || cb >= 8) begin
      f = 4'b0011;
      v = s || ca == 9 || cb == 9;
    end else begin
      v = 1'b0;
      if (rank(ca) == rank(cb)) f = 4'b0110;
      else if (rank(ca) < rank(cb)) f = 4'b1000;
      else f = 4'b0010;
    end
    return {f, v};
  endfunction

  task automatic check(string req, logic [3:0] ef, logic ev);
    @(negedge clk);
    n_checks++;
    if (nzcv !== ef || inv !== ev) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h sig=%0b zero=%0b got nzcv=%b inv=%b exp nzcv=%b inv=%b",
               req, opa, opb, sig_all, vs_zero, nzcv, inv, ef, ev);
    end
  endtask

  // {a, b, sig, zero, nzcv, inv}
  localparam logic [70:0] VEC [12] = '{
    {32'h3f80_0000, 32'h4000_0000, 1'b0, 1'b0, 4'b1000, 1'b0},
    {32'hbf80_0000, 32'hc000_0000, 1'b0, 1'b0, 4'b0010, 1'b0},
    {32'h0000_0002, 32'h0000_0001, 1'b0, 1'b0, 4'b0010, 1'b0},
    {32'h8000_0001, 32'h8000_0002, 1'b0, 1'b0, 4'b0010, 1'b0},
    {32'h7fc0_0000, 32'h3f80_0000, 1'b0, 1'b0, 4'b0011, 1'b0},
    {32'h7fc0_0000, 32'h3f80_0000, 1'b1, 1'b0, 4'b0011, 1'b1},
    {32'h7f80_0001, 32'h0000_0000, 1'b0, 1'b0, 4'b0011, 1'b1},
    {32'h3f80_0000, 32'h7fc0_0000, 1'b1, 1'b1, 4'b0010, 1'b0},
    {32'h8000_0000, 32'hdead_beef, 1'b0, 1'b1, 4'b0110, 1'b0},
    {32'hc000_0000, 32'h1234_5678, 1'b0, 1'b1, 4'b1000, 1'b0},
    {32'h7fc0_0000, 32'h0000_0000, 1'b0, 1'b1, 4'b0011, 1'b0},
    {32'h7f7f_ffff, 32'h7f80_0000, 1'b0, 1'b0, 4'b1000, 1'b0}
  };

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog expired");
          $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
          $finish;
        end
      end
    join_none

    // initial state: all-zero inputs compare equal (R4)
    opa = '0; opb = '0; sig_all = 0; vs_zero = 0;
    check("R4 idle zero", 4'b0110, 1'b0);

    // directed vector table: R6 ordering, R2/R3 invalid, R7 zero substitution
    for (int i = 0; i < 12; i++) begin
      opa = VEC[i][70:39]; opb = VEC[i][38:7];
      sig_all = VEC[i][6]; vs_zero = VEC[i][5];
      check("R6/R2/R3/R7 table", VEC[i][4:1], VEC[i][0]);
    end

    // all class pairings in both flavours (R1 R2 R3 R4 R5 R6 R8 R9)
    vs_zero = 0;
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 10; a++) begin
        for (int b = 0; b < 10; b++) begin
          logic [4:0] e;
          opa = enc(a); opb = enc(b); sig_all = s[0];
          e = model(a, b, s[0]);
          check("R1/R2/R3/R4/R5/R6 pairs", e[4:1], e[0]);
        end
      end
    end

    // R7: poisoned right operand must be ignored under zero substitution
    vs_zero = 1; sig_all = 0;
    for (int a = 0; a < 10; a++) begin
      logic [4:0] e;
      opa = enc(a); opb = 32'h7f80_0001;
      e = model(a, 0, 1'b0);
      check("R7 zero substitution", e[4:1], e[0]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule